// File: doc/BRIEF.md
# Logic Analyzer Input Sampler

The sampler takes a 16-bit group of digital input pins and captures them at a programmable rate. A fractional rate divider sets the rate. The captured samples are packed into 32-bit words, which leave the block on a valid/ready stream for a downstream memory writer.

Each sample is either one byte or one halfword. In byte mode the byte comes from the lower pin group, or from the upper pin group when the lower group is switched off. Samples enter the word from the right, so the oldest sample ends up in the most significant position. A full word is offered on the output without any prompting.

Software-level control is reduced to three pulses:
- `start` begins a capture.
- `stop` ends it and discards anything partly collected.
- `flush` pushes out a partly filled word.

If a word completes while the previous one is still waiting on the output, the new word is dropped and a sticky overflow flag is raised.

Top module: `la_sampler`

## Requirements
- R1: After reset `running`, `out_valid` and `overflow` are 0.
- R2: Byte mode (`half_mode`=0, `upper_lane`=0) takes `pins[7:0]` at each sample. New samples shift in at the LSB end. After four samples the word is offered, with the first sample in bits 31:24 and the fourth in bits 7:0.
- R3: Byte mode with `upper_lane`=1 takes `pins[15:8]` instead of `pins[7:0]`. Packing order is the same as R2.
- R4: Halfword mode (`half_mode`=1) takes `pins[15:0]` and ignores `upper_lane`. Two samples make a word, with the first sample in bits 31:16.
- R5: `rate_div[23:8]` is the integer period I. With a zero fraction, samples are taken every I cycles. The first sample is taken on the I-th rising edge after the edge that registers `start`. I=0 behaves as I=1.
- R6: `rate_div[7:0]` is a fraction F. An 8-bit accumulator starts at 0 on `start` and adds F at each sample. A carry out of the accumulator lengthens the next period by one cycle.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` stays unchanged. A word is consumed on an edge where both are 1.
- R8: A word that completes while the output holds an unaccepted word is dropped. `overflow` goes to 1 and stays there until the next `start`.
- R9: A `flush` pulse emits the partly filled word, right-aligned with zeros above the collected samples. A sample taken in the same cycle is included. A `flush` with no collected samples emits nothing.
- R10: A `stop` pulse clears `running`, the partial word, the pending output word and the divider phase. When `stop` and `start` are both high in the same cycle, `stop` wins. The next capture starts with no stale bits.
- R11: While `running`=0 no samples are taken and no word is produced, whatever `pins` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse: begin a capture, clear the overflow flag |
| stop | input | 1 | Pulse: end the capture and discard partial data |
| flush | input | 1 | Pulse: emit the partly filled word |
| half_mode | input | 1 | 1 = 16-bit samples, 0 = 8-bit samples |
| upper_lane | input | 1 | Byte mode: take pins 15:8 instead of pins 7:0 |
| rate_div | input | 24 | Sample period: integer in bits 23:8, fraction in bits 7:0 |
| pins | input | 16 | Sampled input pins |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Packed sample word |
| overflow | output | 1 | Sticky: a word was dropped |
| running | output | 1 | Capture is active |

## Verification
Most internal faults in this block show up at the ports within one output word:
- A wrong fill count or lane choice shows as misplaced or wrong bytes in the very next `out_data`.
- A divider phase error shifts the edge on which `out_valid` rises by one or more cycles. Cycle-exact latency from `start` to the first word, across several integer and fractional settings, exposes it within four sample periods.
- Stale shift contents after `stop` or after a flushed word appear as foreign bits in the first word of the following capture.
- A missing overflow path appears as either a changed held word or a flag that stays low.

// File: rtl/la_pkg.sv
package la_pkg;
    typedef enum logic {
        SMP_BYTE = 1'b0,
        SMP_HALF = 1'b1
    } smp_mode_e;
endpackage

// File: rtl/la_rate_div.sv
module la_rate_div #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick
);
    typedef struct packed {
        logic [INT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
        logic              extra;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [INT_W:0] int_eff;
    logic [INT_W:0] lim;
    logic [FRAC_W:0] acc_sum;

    always_comb begin
        int_eff = (div_int == '0) ? (INT_W+1)'(1) : {1'b0, div_int};
        lim     = int_eff + (INT_W+1)'(st_q.extra);
        tick    = run && (({1'b0, st_q.cnt} + (INT_W+1)'(1)) == lim);
        acc_sum = {1'b0, st_q.acc} + {1'b0, div_frac};
        st_d    = st_q;
        if (restart) begin
            st_d = '0;
        end else if (tick) begin
            st_d.cnt   = '0;
            st_d.acc   = acc_sum[FRAC_W-1:0];
            st_d.extra = acc_sum[FRAC_W];
        end else if (run) begin
            st_d.cnt = st_q.cnt + INT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && div_int > INT_W'(1) && $stable(div_int)) |=> !tick);
endmodule

// File: rtl/la_lane_sel.sv
module la_lane_sel
    import la_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  smp_mode_e           mode,
    input  logic                upper_lane,
    input  logic [2*LANE_W-1:0] pins,
    output logic [2*LANE_W-1:0] sample
);
    always_comb begin
        if (mode == SMP_HALF)  sample = pins;
        else if (upper_lane)   sample = {{LANE_W{1'b0}}, pins[2*LANE_W-1:LANE_W]};
        else                   sample = {{LANE_W{1'b0}}, pins[LANE_W-1:0]};
    end
endmodule

// File: rtl/la_packer.sv
module la_packer
    import la_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                ovf_clr,
    input  logic                tick,
    input  smp_mode_e           mode,
    input  logic [2*LANE_W-1:0] sample,
    input  logic                flush,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_data,
    output logic                overflow
);
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int HALF_W = 2 * LANE_W;

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  fill;
        logic              ov_valid;
        logic [WORD_W-1:0] ov_data;
        logic              ovf;
    } pk_st_t;

    pk_st_t st_d, st_q;
    logic [WORD_W-1:0] nsh;
    logic [CNT_W-1:0]  nfill;
    logic              emit;

    always_comb begin
        st_d  = st_q;
        nsh   = st_q.sh;
        nfill = st_q.fill;
        if (st_q.ov_valid && out_ready) st_d.ov_valid = 1'b0;
        if (tick) begin
            if (mode == SMP_HALF) begin
                nsh   = {st_q.sh[WORD_W-HALF_W-1:0], sample};
                nfill = st_q.fill + CNT_W'(HALF_W);
            end else begin
                nsh   = {st_q.sh[WORD_W-LANE_W-1:0], sample[LANE_W-1:0]};
                nfill = st_q.fill + CNT_W'(LANE_W);
            end
        end
        emit = (nfill == CNT_W'(WORD_W)) || (flush && nfill != '0);
        if (emit) begin
            if (!st_q.ov_valid || out_ready) begin
                st_d.ov_valid = 1'b1;
                st_d.ov_data  = nsh;
            end else begin
                st_d.ovf = 1'b1;
            end
            st_d.sh   = '0;
            st_d.fill = '0;
        end else begin
            st_d.sh   = nsh;
            st_d.fill = nfill;
        end
        if (clr) begin
            st_d.sh       = '0;
            st_d.fill     = '0;
            st_d.ov_valid = 1'b0;
        end
        if (ovf_clr) st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ov_valid;
    assign out_data  = st_q.ov_data;
    assign overflow  = st_q.ovf;

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_data)));
    // R8
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(out_valid && !out_ready));
    // R10
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!out_valid && st_q.fill == '0));
endmodule

// File: rtl/la_sampler.sv
module la_sampler
    import la_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8,
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     stop,
    input  logic                     flush,
    input  logic                     half_mode,
    input  logic                     upper_lane,
    input  logic [INT_W+FRAC_W-1:0]  rate_div,
    input  logic [2*LANE_W-1:0]      pins,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [WORD_W-1:0]        out_data,
    output logic                     overflow,
    output logic                     running
);
    logic run_d, run_q;
    logic tick;
    logic [2*LANE_W-1:0] sample;
    smp_mode_e mode;

    assign mode = half_mode ? SMP_HALF : SMP_BYTE;

    always_comb begin
        run_d = run_q;
        if (stop)       run_d = 1'b0;
        else if (start) run_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_d;
    end

    assign running = run_q;

    la_rate_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run_q), .restart(start | stop),
        .div_int(rate_div[INT_W+FRAC_W-1:FRAC_W]), .div_frac(rate_div[FRAC_W-1:0]),
        .tick(tick)
    );

    la_lane_sel #(.LANE_W(LANE_W)) u_lane (
        .mode(mode), .upper_lane(upper_lane), .pins(pins), .sample(sample)
    );

    la_packer #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .clr(start | stop), .ovf_clr(start & ~stop),
        .tick(tick), .mode(mode), .sample(sample), .flush(flush),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .overflow(overflow)
    );

    // R11
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !tick);
    // R10
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !running);
endmodule

// File: tb/sim_la_sampler.sv
module sim_la_sampler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, stop = 1'b0, flush = 1'b0;
    logic        half_mode = 1'b0, upper_lane = 1'b0, out_ready = 1'b0;
    logic [23:0] rate_div = 24'h000100;
    logic [15:0] pins = '0;
    logic        out_valid, overflow, running;
    logic [31:0] out_data;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    la_sampler u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .flush(flush),
        .half_mode(half_mode), .upper_lane(upper_lane), .rate_div(rate_div),
        .pins(pins), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .overflow(overflow), .running(running)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic hm, input logic ul, input logic [15:0] ip, input logic [7:0] fr);
        half_mode = hm; upper_lane = ul; rate_div = {ip, fr}; out_ready = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_stop();
        stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic feed(input logic [15:0] v);
        pins = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(!running && !out_valid && !overflow, "R1 reset state",
              {29'd0, running, out_valid, overflow}, 32'd0);
        for (int i = 0; i < 8; i++) feed(16'(i * 16'h1111));
        flush = 1'b1; feed(16'hFFFF); flush = 1'b0;
        check(!out_valid && !running, "R11 idle pins no word", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_byte_lower();
        cfg(1'b0, 1'b0, 16'd1, 8'd0);
        pulse_start();
        feed(16'hAA11); feed(16'hBB22); feed(16'hCC33); feed(16'hDD44);
        check(out_valid && out_data == 32'h11223344, "R2 byte lower word", out_data, 32'h11223344);
        feed(16'h0055); feed(16'h0066);
        check(out_valid && out_data == 32'h11223344, "R7 held while not ready", out_data, 32'h11223344);
        out_ready = 1'b1; feed(16'h0077); out_ready = 1'b0;
        check(!out_valid, "R7 consumed on handshake", {31'd0, out_valid}, 32'd0);
        pulse_stop();
    endtask

    task automatic t_byte_upper();
        cfg(1'b0, 1'b1, 16'd1, 8'd0);
        pulse_start();
        feed(16'h5A01); feed(16'h6B02); feed(16'h7C03); feed(16'h8D04);
        check(out_valid && out_data == 32'h5A6B7C8D, "R3 upper lane word", out_data, 32'h5A6B7C8D);
        pulse_stop();
    endtask

    task automatic t_half();
        cfg(1'b1, 1'b1, 16'd1, 8'd0);
        pulse_start();
        feed(16'h1234); feed(16'hABCD);
        check(out_valid && out_data == 32'h1234ABCD, "R4 halfword word", out_data, 32'h1234ABCD);
        pulse_stop();
    endtask

    task automatic t_overflow();
        cfg(1'b0, 1'b0, 16'd1, 8'd0);
        pulse_start();
        for (int i = 1; i <= 8; i++) feed(16'(i));
        check(overflow == 1'b1, "R8 overflow set", {31'd0, overflow}, 32'd1);
        check(out_data == 32'h01020304, "R8 held word kept", out_data, 32'h01020304);
        feed(16'h0009);
        check(overflow == 1'b1, "R8 overflow sticky", {31'd0, overflow}, 32'd1);
        stop = 1'b0; start = 1'b1; @(negedge clk); start = 1'b0;
        check(overflow == 1'b0, "R8 start clears overflow", {31'd0, overflow}, 32'd0);
        pulse_stop();
    endtask

    task automatic t_flush();
        cfg(1'b0, 1'b0, 16'd1, 8'd0);
        pulse_start();
        feed(16'h0011); feed(16'h0022);
        flush = 1'b1; feed(16'h0033); flush = 1'b0;
        check(out_valid && out_data == 32'h00112233, "R9 partial flush", out_data, 32'h00112233);
        pulse_stop();
        cfg(1'b0, 1'b0, 16'd100, 8'd0);
        pulse_start();
        flush = 1'b1; feed(16'h0044); flush = 1'b0;
        check(!out_valid, "R9 empty flush no word", {31'd0, out_valid}, 32'd0);
        pulse_stop();
    endtask

    task automatic t_stop();
        cfg(1'b0, 1'b0, 16'd1, 8'd0);
        pulse_start();
        for (int i = 0; i < 6; i++) feed(16'h00EE);
        start = 1'b1; stop = 1'b1;
        @(negedge clk); start = 1'b0; stop = 1'b0;
        check(!running && !out_valid, "R10 stop wins and clears",
              {30'd0, running, out_valid}, 32'd0);
        pulse_start();
        feed(16'h00A1); feed(16'h00A2); feed(16'h00A3); feed(16'h00A4);
        check(out_valid && out_data == 32'hA1A2A3A4, "R10 no stale bits", out_data, 32'hA1A2A3A4);
        pulse_stop();
    endtask

    task automatic t_rate(input logic [15:0] ip, input logic [7:0] fr, input int exp, input string tag);
        int n;
        cfg(1'b0, 1'b0, ip, fr);
        pulse_start();
        n = 0;
        while (!out_valid && n < 200) begin
            @(negedge clk); n++;
        end
        check(n == exp, tag, 32'(n), 32'(exp));
        pulse_stop();
    endtask

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_lower();
        t_byte_upper();
        t_half();
        t_overflow();
        t_flush();
        t_stop();
        t_rate(16'd1, 8'd0,   4,  "R5 period 1 latency");
        t_rate(16'd3, 8'd0,   12, "R5 period 3 latency");
        t_rate(16'd0, 8'd0,   4,  "R5 period 0 acts as 1");
        t_rate(16'd2, 8'd128, 9,  "R6 fraction half latency");
        t_rate(16'd1, 8'd255, 6,  "R6 fraction max latency");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule